// File: doc/BRIEF.md
# Three-Stage Instruction Pipeline Sequencer

This block steps instructions through three stages: fetch, decode and execute. It sends a fetch address to an instruction memory and takes the returned word back in the same cycle. Each word then moves one stage per clock. When an instruction leaves execute, the block raises a retire strobe and reports that instruction's address. With no hazards it completes one instruction per clock. Each instruction spends three clocks between its fetch and its retirement.

The block handles two hazards. A load-multiple instruction stays in execute for one cycle for each register named in its mask. During those cycles the fetch address and the decode stage are frozen. A conditional branch is resolved only in execute, against a 1-bit condition input. A taken branch discards the two younger instructions already fetched and restarts fetch at the branch address plus a signed offset. An untaken branch costs nothing. The block holds no register file, no forwarding and no memory interface beyond the fetch port.

Top module: `pipe3_seq`

## Requirements
- R1: While `rst_ni` is low, `retire_o` and `squash_o` are 0 and `imem_addr_o` is 0. The first word fetched after reset comes from address 0.
- R2: An instruction word has 10 bits. Bits [9:8] give the class: 00 = ALU, 01 = load-multiple with its register mask in bits [3:0], 10 = conditional branch with a signed two's-complement offset in bits [7:0], 11 = NOP. Every instruction that is not discarded retires exactly once, and `retire_pc_o` carries its fetch address in that cycle.
- R3: With no hazards, one instruction retires per clock. The word fetched from address k after reset retires in the third clock after the first fetch clock, counted as clock 3+k.
- R4: A load-multiple whose mask has n set bits stays in execute for n cycles; an empty mask counts as one cycle. It retires only in its last execute cycle.
- R5: While a load-multiple holds execute, the fetch address and the decode stage do not change. The instruction behind it retires in the cycle after the load-multiple retires.
- R6: A branch samples `cond_i` in its execute cycle; 1 means taken. An untaken branch retires with `squash_o` low and adds no bubble.
- R7: A taken branch raises `squash_o` in the same cycle it retires. The two younger instructions then in fetch and decode never retire. Fetch restarts at the branch address plus the sign-extended offset, and the target retires three cycles after the branch.
- R8: A load-multiple that sits in decode when a taken branch is in execute is discarded. It never retires and never holds execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | PC_W | Fetch address to instruction memory |
| imem_data_i | input | 2+OFF_W | Instruction word at `imem_addr_o`, same cycle |
| cond_i | input | 1 | Branch condition, sampled while a branch executes |
| retire_o | output | 1 | An instruction leaves execute this cycle |
| retire_pc_o | output | PC_W | Address of the retiring instruction |
| squash_o | output | 1 | Retiring branch is taken; younger work is discarded |

## Verification
Two functions can meet in a single cycle. A taken branch can resolve in execute while a load-multiple waits in decode. The reverse can also happen: a branch can sit frozen in decode behind a load-multiple in execute and then resolve as soon as it enters execute. Both orders are produced with short directed programs held in a memory model inside the bench, with `cond_i` tied high. The result is judged from the per-cycle retire trace. The squashed load-multiple must leave no retirement and no stall cycles. The frozen branch must retire in the cycle after the load-multiple, and its target must appear exactly three cycles later.

// File: rtl/pipe3_pkg.sv
`timescale 1ns/1ps
package pipe3_pkg;
  typedef enum logic [1:0] {
    CLS_ALU = 2'b00,
    CLS_LDM = 2'b01,
    CLS_BR  = 2'b10,
    CLS_NOP = 2'b11
  } cls_e;
endpackage

// File: rtl/pipe3_fetch.sv
`timescale 1ns/1ps
module pipe3_fetch #(
  parameter int unsigned PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] target_i,
  output logic            fetch_v_o,
  output logic [PC_W-1:0] pc_o
);
  logic            v_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= 1'b0;
      pc_q <= '0;
    end else begin
      v_q <= 1'b1;
      if (redirect_i)          pc_q <= target_i;
      else if (v_q && !hold_i) pc_q <= pc_q + 1'b1;
    end
  end

  assign fetch_v_o = v_q;
  assign pc_o      = pc_q;
endmodule

// File: rtl/pipe3_decode.sv
`timescale 1ns/1ps
module pipe3_decode
  import pipe3_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned MASK_W = 4,
  localparam int unsigned IW    = 2 + OFF_W,
  localparam int unsigned CNT_W = $clog2(MASK_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             flush_i,
  input  logic             fetch_v_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic [IW-1:0]    fetch_word_i,
  output logic             dec_v_o,
  output logic [PC_W-1:0]  dec_pc_o,
  output cls_e             dec_cls_o,
  output logic [OFF_W-1:0] dec_pay_o,
  output logic [CNT_W-1:0] dec_extra_o
);
  logic             v_q;
  logic [PC_W-1:0]  pc_q;
  cls_e             cls_q;
  logic [OFF_W-1:0] pay_q;
  logic [CNT_W-1:0] ones;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      pc_q  <= '0;
      cls_q <= CLS_NOP;
      pay_q <= '0;
    end else if (flush_i) begin
      v_q <= 1'b0;
    end else if (!hold_i) begin
      v_q   <= fetch_v_i;
      pc_q  <= fetch_pc_i;
      cls_q <= cls_e'(fetch_word_i[IW-1 -: 2]);
      pay_q <= fetch_word_i[OFF_W-1:0];
    end
  end

  // register count of load-multiple mask
  always_comb begin
    ones = '0;
    for (int i = 0; i < MASK_W; i++) ones = ones + CNT_W'(pay_q[i]);
  end

  // extra execute cycles beyond the first
  assign dec_extra_o = (cls_q == CLS_LDM && ones != '0) ? ones - 1'b1 : '0;
  assign dec_v_o     = v_q;
  assign dec_pc_o    = pc_q;
  assign dec_cls_o   = cls_q;
  assign dec_pay_o   = pay_q;
endmodule

// File: rtl/pipe3_exec.sv
`timescale 1ns/1ps
module pipe3_exec
  import pipe3_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned MASK_W = 4,
  localparam int unsigned CNT_W = $clog2(MASK_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_v_i,
  input  logic [PC_W-1:0]  dec_pc_i,
  input  cls_e             dec_cls_i,
  input  logic [OFF_W-1:0] dec_pay_i,
  input  logic [CNT_W-1:0] dec_extra_i,
  input  logic             cond_i,
  output logic             stall_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  target_o,
  output logic             retire_o,
  output logic [PC_W-1:0]  retire_pc_o
);
  logic             v_q;
  logic [PC_W-1:0]  pc_q;
  cls_e             cls_q;
  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PC_W-1:0]  off_ext;

  assign stall_o  = v_q && cls_q == CLS_LDM && cnt_q != '0;
  assign taken_o  = v_q && cls_q == CLS_BR && cond_i;
  assign retire_o = v_q && !stall_o;
  assign off_ext  = PC_W'($signed(off_q));
  assign target_o = pc_q + off_ext;
  assign retire_pc_o = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      pc_q  <= '0;
      cls_q <= CLS_NOP;
      off_q <= '0;
      cnt_q <= '0;
    end else if (stall_o) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      v_q   <= dec_v_i && !taken_o;
      pc_q  <= dec_pc_i;
      cls_q <= dec_cls_i;
      off_q <= dec_pay_i;
      cnt_q <= dec_extra_i;
    end
  end
endmodule

// File: rtl/pipe3_seq.sv
`timescale 1ns/1ps
module pipe3_seq
  import pipe3_pkg::*;
#(
  parameter int unsigned PC_W   = 8,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned MASK_W = 4,
  localparam int unsigned IW    = 2 + OFF_W,
  localparam int unsigned CNT_W = $clog2(MASK_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PC_W-1:0] imem_addr_o,
  input  logic [IW-1:0]   imem_data_i,
  input  logic            cond_i,
  output logic            retire_o,
  output logic [PC_W-1:0] retire_pc_o,
  output logic            squash_o
);
  logic             stall, taken, fetch_v, dec_v;
  logic [PC_W-1:0]  target, pc, dec_pc;
  cls_e             dec_cls;
  logic [OFF_W-1:0] dec_pay;
  logic [CNT_W-1:0] dec_extra;

  pipe3_fetch #(.PC_W(PC_W)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(stall), .redirect_i(taken),
    .target_i(target), .fetch_v_o(fetch_v), .pc_o(pc)
  );

  pipe3_decode #(.PC_W(PC_W), .OFF_W(OFF_W), .MASK_W(MASK_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(stall), .flush_i(taken),
    .fetch_v_i(fetch_v), .fetch_pc_i(pc), .fetch_word_i(imem_data_i),
    .dec_v_o(dec_v), .dec_pc_o(dec_pc), .dec_cls_o(dec_cls),
    .dec_pay_o(dec_pay), .dec_extra_o(dec_extra)
  );

  pipe3_exec #(.PC_W(PC_W), .OFF_W(OFF_W), .MASK_W(MASK_W)) u_ex (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_v_i(dec_v), .dec_pc_i(dec_pc),
    .dec_cls_i(dec_cls), .dec_pay_i(dec_pay), .dec_extra_i(dec_extra),
    .cond_i(cond_i), .stall_o(stall), .taken_o(taken), .target_o(target),
    .retire_o(retire_o), .retire_pc_o(retire_pc_o)
  );

  assign imem_addr_o = pc;
  assign squash_o    = taken;
endmodule

// File: rtl/pipe3_seq_chk.sv
`timescale 1ns/1ps
module pipe3_seq_chk #(
  parameter int unsigned PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            retire_i,
  input logic            squash_i,
  input logic            stall_i,
  input logic [PC_W-1:0] addr_i
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!retire_i && !squash_i && addr_i == '0); // R1
    end
  end

  AST_STALL_NO_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !retire_i); // R4

  AST_STALL_HOLDS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(addr_i)); // R5

  AST_SQUASH_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |-> retire_i); // R7

  AST_SQUASH_BUBBLE_1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> !retire_i); // R7

  AST_SQUASH_BUBBLE_2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> ##1 !retire_i); // R7
endmodule

bind pipe3_seq pipe3_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_o), .squash_i(squash_o),
  .stall_i(stall), .addr_i(imem_addr_o)
);

// File: tb/tb_pipe3_seq.sv
`timescale 1ns/1ps
module tb_pipe3_seq;
  localparam int PC_W = 8;
  localparam int IW   = 10;
  localparam int MAXC = 32;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [PC_W-1:0] imem_addr;
  logic [IW-1:0]   imem_data;
  logic            cond;
  logic            retire;
  logic [PC_W-1:0] retire_pc;
  logic            squash;

  logic [IW-1:0] mem [0:255];
  int exp_pc [0:MAXC-1];
  bit exp_sq [0:MAXC-1];
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;
  assign imem_data = mem[imem_addr];

  pipe3_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .cond_i(cond), .retire_o(retire), .retire_pc_o(retire_pc), .squash_o(squash)
  );

  function automatic logic [IW-1:0] w_alu();             return {2'b00, 8'h00}; endfunction
  function automatic logic [IW-1:0] w_nop();             return {2'b11, 8'h00}; endfunction
  function automatic logic [IW-1:0] w_ldm(logic [3:0] m); return {2'b01, 4'h0, m}; endfunction
  function automatic logic [IW-1:0] w_br(logic [7:0] o);  return {2'b10, o}; endfunction

  task automatic clear_prog();
    for (int a = 0; a < 256; a++) mem[a] = (a % 2 == 0) ? w_alu() : w_nop();
    for (int c = 0; c < MAXC; c++) begin exp_pc[c] = -1; exp_sq[c] = 1'b0; end
  endtask

  task automatic check(input string req, input bit ok, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // reset, then compare the retire/squash trace cycle by cycle
  task automatic run_trace(input string req, input int ncyc);
    @(negedge clk); rst_ni = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R1", !retire && !squash, "retire/squash in reset", {retire, squash}, 0);
    check("R1", imem_addr == 0, "fetch address in reset", imem_addr, 0);
    @(negedge clk); rst_ni = 1'b1;
    for (int c = 1; c <= ncyc; c++) begin
      int got;
      @(posedge clk); #1;
      got = retire ? int'(retire_pc) : -1;
      check(req, got == exp_pc[c], $sformatf("cycle %0d retire_pc", c), got, exp_pc[c]);
      check(req, squash == exp_sq[c], $sformatf("cycle %0d squash", c), squash, exp_sq[c]);
    end
  endtask

  task automatic t_straight();
    clear_prog(); cond = 1'b1;
    for (int c = 3; c <= 14; c++) exp_pc[c] = c - 3;
    run_trace("R3", 14); // R2 R3: one per clock, three-cycle latency
  endtask

  task automatic t_ldm(input logic [3:0] mask, input int n);
    clear_prog(); cond = 1'b0;
    mem[0] = w_ldm(mask);
    exp_pc[2 + n] = 0;
    for (int c = 3 + n; c <= 14; c++) exp_pc[c] = c - 2 - n;
    run_trace("R4/R5", 14); // R4 R5
  endtask

  task automatic t_br_not_taken();
    clear_prog(); cond = 1'b0;
    mem[2] = w_br(8'd5);
    for (int c = 3; c <= 14; c++) exp_pc[c] = c - 3;
    run_trace("R6", 14); // R6
  endtask

  task automatic t_br_fwd();
    clear_prog(); cond = 1'b1;
    mem[2] = w_br(8'd5);
    exp_pc[3] = 0; exp_pc[4] = 1; exp_pc[5] = 2; exp_sq[5] = 1'b1;
    for (int c = 8; c <= 14; c++) exp_pc[c] = c - 1;
    run_trace("R7", 14); // R7 forward target 7
  endtask

  task automatic t_br_back();
    clear_prog(); cond = 1'b1;
    mem[6] = w_br(8'hFC);
    for (int c = 3; c <= 9; c++) exp_pc[c] = c - 3;
    exp_sq[9] = 1'b1;
    exp_pc[12] = 2; exp_pc[13] = 3; exp_pc[14] = 4;
    run_trace("R7", 14); // R7 backward target 2
  endtask

  task automatic t_br_over_ldm();
    clear_prog(); cond = 1'b1;
    mem[1] = w_br(8'd4);
    mem[2] = w_ldm(4'b1111);
    exp_pc[3] = 0; exp_pc[4] = 1; exp_sq[4] = 1'b1;
    for (int c = 7; c <= 12; c++) exp_pc[c] = c - 2;
    run_trace("R8", 12); // R8: squashed load-multiple never stalls
  endtask

  task automatic t_ldm_then_br();
    clear_prog(); cond = 1'b1;
    mem[0] = w_ldm(4'b0011);
    mem[1] = w_br(8'd3);
    exp_pc[4] = 0; exp_pc[5] = 1; exp_sq[5] = 1'b1;
    for (int c = 8; c <= 13; c++) exp_pc[c] = c - 4;
    run_trace("R5/R7", 13); // R5 R7: frozen branch resolves after load
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; cond = 1'b0;
    clear_prog();
    t_straight();
    t_ldm(4'b0011, 2);
    t_ldm(4'b1111, 4);
    t_ldm(4'b0000, 1);
    t_ldm(4'b0101, 2);
    t_br_not_taken();
    t_br_fwd();
    t_br_back();
    t_br_over_ldm();
    t_ldm_then_br();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule